// File: doc/BRIEF.md
# Status Register and Write-Protection Unit

This block keeps the 8-bit status byte of a serial memory. It decides whether a status write or an array write may go ahead. A command front-end gives it one-cycle strobes: write-enable, write-disable, status-write with its data byte and a frame-length flag, and array-write-done. The block also samples the active-low write-protect pin and a busy flag from the array write engine. It returns the status byte for a status read, the write-enable latch, the block-protect field that is in force, and a combinational flag that says whether a given array address is read-only.

An accepted status write starts a self-timed cycle. The cycle lasts `WRSR_CYCLES` system clocks, and during it the previous protection settings remain in force. The new protect bits take effect only on the completion clock. The protect and write-disable bits stand in for non-volatile cells. `rst_ni` loads their factory value of zero. The synchronous soft reset `soft_rst_i` models a power cycle: it clears the volatile state, abandons any status write that is running, and keeps the stored bits.

Top module: `stat_wp_unit`

## Requirements
- R1: After `rst_ni` the status byte is 0x00, `wel_o` is 0, `bp_o` is 0 and no address is protected.
- R2: Status bit positions: bit 7 is the status-write-disable bit (SRWD), bits 6..4 always read 0, bits 3..2 are the block-protect field (bit 3 high), bit 1 is the write-enable latch (WEL), and bit 0 is write-in-progress (WIP).
- R3: `wren_i` sets WEL on the next clock. `wrdi_i` and `array_wr_done_i` clear it on the next clock, and a clear takes priority over a set.
- R4: A status write is accepted only if three things hold together: WEL=1, WIP=0, and `wrsr_frame_ok_i`=1. Otherwise it has no effect on the status byte.
- R5: An accepted status write loads data bits 7, 3 and 2 into SRWD and the block-protect field. It leaves bits 6..4, 1 and 0 of the status byte untouched.
- R6: When SRWD=1 and `wp_ni`=0 (hardware lock), a status write is rejected even with WEL=1. The lock applies whichever of the two conditions became true first. With `wp_ni`=1 the write is accepted.
- R7: The protected region for an array of 2^ADDR_W bytes depends on the block-protect field: 00 protects nothing, 01 protects the top quarter, 10 protects the top half, and 11 protects every address.
- R8: Once a status write is accepted, WIP reads 1 for exactly `WRSR_CYCLES` clocks. The old SRWD and block-protect values stay visible and in force until the clock on which WIP falls, and the new values take effect on that same clock.
- R9: WEL clears on the clock that completes a status write.
- R10: `soft_rst_i` clears WEL and WIP and abandons any status write in progress. SRWD and the block-protect field keep their values.
- R11: WIP also reflects `engine_busy_i`, and a status write is rejected while the engine is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, factory initialisation |
| soft_rst_i | input | 1 | Synchronous power-cycle reset, keeps the stored bits |
| wren_i | input | 1 | Write-enable strobe |
| wrdi_i | input | 1 | Write-disable strobe |
| wrsr_i | input | 1 | Status-write strobe at the end of the frame |
| wrsr_frame_ok_i | input | 1 | Frame ended right after a whole data byte |
| wrsr_data_i | input | 8 | Status-write data byte |
| array_wr_done_i | input | 1 | Array write completed |
| engine_busy_i | input | 1 | Array write engine busy |
| wp_ni | input | 1 | Write-protect pin, active low |
| chk_addr_i | input | ADDR_W | Array address to classify |
| status_o | output | 8 | Status byte for a status read |
| wel_o | output | 1 | Write-enable latch |
| bp_o | output | 2 | Block-protect field in force |
| addr_prot_o | output | 1 | `chk_addr_i` lies in the protected region |

## Verification
A wrong acceptance decision shows in `status_o` on the very next clock. WIP rises when it should stay low, or stays low when it should rise. WEL, WIP, SRWD and the block-protect field are read directly from the port, so a fault in any of them cannot hide. If the cycle counter is off by even one clock, the cycle ends early or late, and a clock-by-clock sample of WIP and `bp_o` across the whole cycle catches it. A fault in the address decode shows at once on `addr_prot_o`, and sweeping every address under each protect setting finds a wrong boundary.

// File: rtl/stat_wp_pkg.sv
package stat_wp_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned SRWD_POS = 7;
  localparam int unsigned BPH_POS = 3;
  localparam int unsigned BPL_POS = 2;
  localparam int unsigned WEL_POS = 1;
  localparam int unsigned WIP_POS = 0;

  typedef struct packed {
    logic       srwd;
    logic [1:0] bp;
  } nv_bits_t;

  function automatic nv_bits_t nv_from_byte(input logic [STAT_W-1:0] d);
    nv_bits_t n;
    n.srwd = d[SRWD_POS];
    n.bp   = d[BPH_POS:BPL_POS];
    return n;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input nv_bits_t n, input logic wel,
                                                    input logic wip);
    logic [STAT_W-1:0] s;
    s = '0;
    s[SRWD_POS] = n.srwd;
    s[BPH_POS:BPL_POS] = n.bp;
    s[WEL_POS] = wel;
    s[WIP_POS] = wip;
    return s;
  endfunction
endpackage

// File: rtl/stat_wel_ctl.sv
module stat_wel_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic abort_i,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  logic wel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wel_q <= 1'b0;
    else if (abort_i)  wel_q <= 1'b0;
    else if (clr_i)    wel_q <= 1'b0;
    else if (set_i)    wel_q <= 1'b1;
  end

  assign wel_o = wel_q;

  p_wel_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !clr_i && !abort_i |=> wel_o)
    else $error("WEL not set");
  p_wel_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !wel_o)
    else $error("WEL not cleared");
endmodule

// File: rtl/stat_cycle_timer.sv
module stat_cycle_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic abort_i,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0) && !abort_i;

  p_done_ends_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o)
    else $error("cycle did not end");
  p_busy_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (cnt_q != '0) && !abort_i |=> busy_o)
    else $error("cycle ended early");
endmodule

// File: rtl/stat_region_decode.sv
module stat_region_decode #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic [1:0]        bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);
  localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(3) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);

  logic [ADDR_W-1:0] base;

  always_comb begin
    unique case (bp_i)
      2'b01:   base = QTR_BASE;
      2'b10:   base = HALF_BASE;
      default: base = '0;
    endcase
    prot_o = (bp_i != 2'b00) && (addr_i >= base);
  end
endmodule

// File: rtl/stat_wp_unit.sv
module stat_wp_unit
  import stat_wp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned WRSR_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic              wrsr_frame_ok_i,
  input  logic [STAT_W-1:0] wrsr_data_i,
  input  logic              array_wr_done_i,
  input  logic              engine_busy_i,
  input  logic              wp_ni,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic [STAT_W-1:0] status_o,
  output logic              wel_o,
  output logic [1:0]        bp_o,
  output logic              addr_prot_o
);
  nv_bits_t nv_q, pend_q;
  logic     wel, wip, hw_lock, accept, sr_busy, sr_done;

  assign hw_lock = nv_q.srwd && !wp_ni;
  assign wip     = sr_busy || engine_busy_i;
  assign accept  = wrsr_i && wrsr_frame_ok_i && wel && !wip && !hw_lock && !soft_rst_i;

  stat_wel_ctl u_wel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .abort_i(soft_rst_i),
    .set_i  (wren_i),
    .clr_i  (wrdi_i || array_wr_done_i || sr_done),
    .wel_o  (wel)
  );

  stat_cycle_timer #(.CYCLES(WRSR_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .abort_i(soft_rst_i),
    .start_i(accept),
    .busy_o (sr_busy),
    .done_o (sr_done)
  );

  // stored bits: factory zero on rst_ni only, untouched by soft reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nv_q   <= '0;
      pend_q <= '0;
    end else begin
      if (accept)  pend_q <= nv_from_byte(wrsr_data_i);
      if (sr_done) nv_q   <= pend_q;
    end
  end

  stat_region_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bp_i  (nv_q.bp),
    .addr_i(chk_addr_i),
    .prot_o(addr_prot_o)
  );

  assign status_o = pack_status(nv_q, wel, wip);
  assign wel_o    = wel;
  assign bp_o     = nv_q.bp;

  p_hw_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrsr_i && nv_q.srwd && !wp_ni |=> !$rose(sr_busy))
    else $error("status write accepted under hardware lock");
  p_no_wel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrsr_i && !wel && !sr_busy |=> !sr_busy)
    else $error("status write accepted without WEL");
  p_old_bits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_busy && !sr_done |=> $stable(nv_q))
    else $error("protect bits changed mid cycle");
  p_wel_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_done |=> !wel_o)
    else $error("WEL kept after status write");
  p_soft_rst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !wel_o && !sr_busy && $stable(nv_q))
    else $error("soft reset misbehaved");
  p_engine_wip_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    engine_busy_i |-> status_o[WIP_POS])
    else $error("WIP low while engine busy");
endmodule

// File: tb/stat_wp_unit_tb.sv
module stat_wp_unit_tb;
  localparam int unsigned AW = 13;
  localparam int unsigned CYC = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic soft_rst_i = 0, wren_i = 0, wrdi_i = 0, wrsr_i = 0, frame_ok = 0;
  logic [7:0] wrsr_data_i = '0;
  logic array_wr_done_i = 0, engine_busy_i = 0, wp_ni = 1;
  logic [AW-1:0] chk_addr_i = '0;
  logic [7:0] status_o;
  logic wel_o, addr_prot_o;
  logic [1:0] bp_o;

  int checks = 0, errors = 0;
  logic e_srwd = 0, e_wel = 0;
  logic [1:0] e_bp = 0;

  always #10 clk = ~clk;

  stat_wp_unit #(.ADDR_W(AW), .WRSR_CYCLES(CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i), .wren_i(wren_i), .wrdi_i(wrdi_i),
    .wrsr_i(wrsr_i), .wrsr_frame_ok_i(frame_ok), .wrsr_data_i(wrsr_data_i),
    .array_wr_done_i(array_wr_done_i), .engine_busy_i(engine_busy_i), .wp_ni(wp_ni),
    .chk_addr_i(chk_addr_i), .status_o(status_o), .wel_o(wel_o), .bp_o(bp_o),
    .addr_prot_o(addr_prot_o)
  );

  function automatic logic [7:0] exp_stat(input logic wip);
    return {e_srwd, 3'b000, e_bp, e_wel, wip};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_wren;
    @(negedge clk) wren_i = 1;
    @(negedge clk) wren_i = 0;
  endtask

  // issue a status write; returns at the negedge after the sampling edge
  task automatic issue_wrsr(input logic [7:0] d, input logic ok);
    @(negedge clk) begin wrsr_i = 1; frame_ok = ok; wrsr_data_i = d; end
    @(negedge clk) begin wrsr_i = 0; frame_ok = 0; end
  endtask

  // full accepted status write with per-cycle WIP and old-bit checks
  task automatic timed_wrsr(input logic [7:0] d);
    pulse_wren;
    e_wel = 1;
    issue_wrsr(d, 1);
    for (int i = 0; i < CYC; i++) begin
      check("R8 wip during cycle", status_o, exp_stat(1'b1));
      @(negedge clk);
    end
    e_srwd = d[7]; e_bp = d[3:2]; e_wel = 0;
    check("R5/R8/R9 after completion", status_o, exp_stat(1'b0));
  endtask

  task automatic sweep_addr;
    for (int a = 0; a < (1 << AW); a++) begin
      logic e;
      chk_addr_i = AW'(a);
      #1;
      case (e_bp)
        2'b01:   e = (a >= 3 * (1 << (AW - 2)));
        2'b10:   e = (a >= (1 << (AW - 1)));
        2'b11:   e = 1'b1;
        default: e = 1'b0;
      endcase
      check("R7 region", addr_prot_o, e);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1
    check("R1 status", status_o, 8'h00);
    check("R1 wel", wel_o, 0);
    check("R1 bp", bp_o, 0);
    chk_addr_i = '1; #1;
    check("R1 prot", addr_prot_o, 0);

    // R3
    pulse_wren; check("R3 wren", status_o, 8'h02);
    @(negedge clk) wrdi_i = 1; @(negedge clk) wrdi_i = 0;
    check("R3 wrdi", status_o, 8'h00);
    pulse_wren;
    @(negedge clk) array_wr_done_i = 1; @(negedge clk) array_wr_done_i = 0;
    check("R3 array done", status_o, 8'h00);
    @(negedge clk) begin wren_i = 1; wrdi_i = 1; end
    @(negedge clk) begin wren_i = 0; wrdi_i = 0; end
    check("R3 clear priority", wel_o, 0);

    // R4: no WEL, then bad frame, then R11 engine busy
    issue_wrsr(8'h8C, 1);
    repeat (2) @(negedge clk);
    check("R4 no wel", status_o, 8'h00);
    pulse_wren; e_wel = 1;
    issue_wrsr(8'h8C, 0);
    repeat (2) @(negedge clk);
    check("R4 bad frame", status_o, exp_stat(0));
    engine_busy_i = 1; #1;
    check("R11 wip from engine", status_o, exp_stat(1));
    issue_wrsr(8'h8C, 1);
    engine_busy_i = 0;
    repeat (2) @(negedge clk);
    check("R11 rejected while busy", status_o, exp_stat(0));
    // R4: status write arriving during a running status write
    issue_wrsr(8'h04, 1);
    issue_wrsr(8'h08, 1);
    for (int i = 0; i < CYC; i++) @(negedge clk);
    e_bp = 2'b01; e_wel = 0;
    check("R4 second write ignored", status_o, exp_stat(0));

    // R5/R8/R9: sweep every data byte with hardware lock open
    for (int d = 0; d < 256; d++) timed_wrsr(8'(d));

    // R7: sweep addresses for each protect setting
    for (int b = 0; b < 4; b++) begin
      timed_wrsr({6'b0, 2'(b)} << 2);
      sweep_addr;
    end

    // R6: set SRWD then drive pin low
    timed_wrsr(8'h84);
    wp_ni = 0;
    pulse_wren; e_wel = 1;
    issue_wrsr(8'h00, 1);
    repeat (2) @(negedge clk);
    check("R6 locked srwd-first", status_o, exp_stat(0));
    wp_ni = 1;
    issue_wrsr(8'h00, 1);
    for (int i = 0; i < CYC; i++) @(negedge clk);
    e_srwd = 0; e_bp = 0; e_wel = 0;
    check("R6 pin high accepts", status_o, exp_stat(0));
    // R6: pin low first, then SRWD set
    wp_ni = 0;
    timed_wrsr(8'h88);
    pulse_wren; e_wel = 1;
    issue_wrsr(8'h00, 1);
    repeat (2) @(negedge clk);
    check("R6 locked pin-first", status_o, exp_stat(0));
    check("R6 bp held", bp_o, 2'b10);
    wp_ni = 1;

    // R10: soft reset keeps stored bits
    @(negedge clk) soft_rst_i = 1; @(negedge clk) soft_rst_i = 0;
    e_wel = 0;
    check("R10 soft reset idle", status_o, exp_stat(0));
    pulse_wren;
    issue_wrsr(8'h04, 1);
    repeat (3) @(negedge clk);
    @(negedge clk) soft_rst_i = 1; @(negedge clk) soft_rst_i = 0;
    check("R10 abort mid cycle", status_o, exp_stat(0));
    repeat (CYC + 2) @(negedge clk);
    check("R10 bits never applied", status_o, exp_stat(0));
    check("R2 bits 6..4 zero", status_o[6:4], 3'b000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule